// File: doc/BRIEF.md
# L1 Data Access Checker

This block sits between two data address generators and the on-chip data memory. It screens every load or store request. It raises an exception with a cause code when an access is illegal, and it picks which of two data ports carries the fetch toward L2.

While the protection lookaside buffers are disabled, only a small set of checks runs:
- address alignment against the access size;
- a reserved address window;
- access rights to the memory-mapped register region.

When the buffers are enabled, this block raises nothing. Checking is then the job of the descriptor lookup, which sits outside this block.

Port choice depends on whether the access is cacheable:
- A cacheable fetch goes to the port wired to the targeted cache bank.
- A non-cacheable fetch goes to the port named by the requesting generator's own preference bit.

The port select is latched at the first cycle of a request and held for as long as the request stays valid. This is done by a two-state controller:
- `ST_IDLE` moves to `ST_HOLD` when `req_valid` is seen. On that move the routed port is loaded.
- `ST_HOLD` stays in `ST_HOLD` while `req_valid` remains high, and the port select is frozen.
- `ST_HOLD` returns to `ST_IDLE` when `req_valid` drops.
- `ST_IDLE` stays in `ST_IDLE` while there is no request.

Top module: `l1_access_checker`

## Requirements
- R1: Outputs are registered: `rsp_valid` equals `req_valid` of the previous cycle, and after reset `rsp_valid`, `rsp_exc`, `rsp_cause` and `port_sel` are all 0.
- R2: With `prot_en`=0, an access whose address is not a multiple of its size gives `rsp_exc`=1 and `rsp_cause`=2'b10. The size codes are 2'b00 = byte (any address), 2'b01 = half-word (bit 0 clear), and 2'b10 or 2'b11 = word (bits 1:0 clear).
- R3: With `prot_en`=0, an aligned access with address in [`RSV_LO`, `RSV_HI`] (default 32'hFF90_0000 to 32'hFF9F_FFFF) gives cause 2'b01.
- R4: With `prot_en`=0, an aligned access from DAG1 (`req_dag`=1) to an address at or above `REG_BASE` (default 32'hFFC0_0000) gives cause 2'b11, in both privilege modes.
- R5: With `prot_en`=0, an aligned access in user mode (`req_user`=1) to the register region gives cause 2'b11. A supervisor access from DAG0 to that region raises no exception.
- R6: While `prot_en`=1, no exception is raised for any request.
- R7: When misalignment coincides with a register-region or reserved-window violation, cause 2'b10 is reported.
- R8: A cacheable request routes to the port equal to `req_bank`, whatever `port_pref` holds.
- R9: A non-cacheable request from DAG0 routes to `port_pref[0]`, and one from DAG1 routes to `port_pref[1]`.
- R10: `port_sel` is loaded one cycle after the first valid cycle of a request and does not change while `req_valid` stays high, even when inputs change.
- R11: A cycle without a request gives `rsp_exc`=0 and `rsp_cause`=2'b00 one cycle later, and `port_sel` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | Access size code |
| req_dag | input | 1 | Requesting generator: 0 or 1 |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_cacheable | input | 1 | Fetch is cacheable |
| req_bank | input | 1 | Targeted cache bank (0 or 1) |
| prot_en | input | 1 | Protection buffers enabled |
| port_pref | input | 2 | Per-generator port preference |
| rsp_valid | output | 1 | Result of previous cycle's request |
| rsp_exc | output | 1 | Exception raised |
| rsp_cause | output | 2 | Exception cause code |
| port_sel | output | 1 | Chosen data port |

## Verification
Exception checking and port routing run on the same request in the same cycle. Their results are judged together, so a correct cause must not come at the cost of a wrong port. It also matters in which cycle `port_sel` may move during a held request.

Two exception causes can also coincide. Directed requests provoke this by being both misaligned and aimed at the register region or the reserved window, and the bench expects the misalignment code. Random requests biased toward the window and region edges mix all causes with both routing modes. Each result is compared against bench functions that apply the priority and routing rules.

// File: rtl/l1chk_pkg.sv
package l1chk_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_RSVD  = 2'b01,
        CAUSE_ALIGN = 2'b10,
        CAUSE_REG   = 2'b11
    } exc_cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } port_state_e;

    typedef struct packed {
        logic rsvd_hit;
        logic reg_hit;
    } region_t;

endpackage

// File: rtl/l1chk_region_decode.sv
module l1chk_region_decode
    import l1chk_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] RSV_LO   = 32'hFF90_0000,
    parameter logic [31:0] RSV_HI   = 32'hFF9F_FFFF,
    parameter logic [31:0] REG_BASE = 32'hFFC0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    localparam logic [ADDR_W-1:0] LO_A  = RSV_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI_A  = RSV_HI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] REG_A = REG_BASE[ADDR_W-1:0];

    always_comb begin
        region.rsvd_hit = (addr >= LO_A) && (addr <= HI_A);
        region.reg_hit  = (addr >= REG_A);
    end

    // R3: reserved window and register region never overlap
    always_comb begin
        reserved_disjoint_chk: assert (!(region.rsvd_hit && region.reg_hit) || $isunknown(addr));
    end
endmodule

// File: rtl/l1chk_align.sv
module l1chk_align
    import l1chk_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       misaligned
);
    acc_size_e sz;

    always_comb begin
        sz = acc_size_e'(size);
        unique case (sz)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo[0];
            SZ_WORD,
            SZ_WIDE: misaligned = |addr_lo;
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/l1chk_port_route.sv
module l1chk_port_route (
    input  logic       dag,
    input  logic       cacheable,
    input  logic       bank,
    input  logic [1:0] pref,
    output logic       sel
);
    always_comb begin
        if (cacheable) sel = bank;
        else           sel = pref[dag];
    end
endmodule

// File: rtl/l1_access_checker.sv
module l1_access_checker
    import l1chk_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] RSV_LO   = 32'hFF90_0000,
    parameter logic [31:0] RSV_HI   = 32'hFF9F_FFFF,
    parameter logic [31:0] REG_BASE = 32'hFFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_dag,
    input  logic              req_user,
    input  logic              req_cacheable,
    input  logic              req_bank,
    input  logic              prot_en,
    input  logic [1:0]        port_pref,
    output logic              rsp_valid,
    output logic              rsp_exc,
    output logic [1:0]        rsp_cause,
    output logic              port_sel
);
    region_t     region;
    logic        misaligned;
    logic        route_sel;
    exc_cause_e  cause_d;
    exc_cause_e  cause_q;
    port_state_e state_q, state_d;

    l1chk_region_decode #(
        .ADDR_W  (ADDR_W),
        .RSV_LO  (RSV_LO),
        .RSV_HI  (RSV_HI),
        .REG_BASE(REG_BASE)
    ) u_region (
        .addr  (req_addr),
        .region(region)
    );

    l1chk_align u_align (
        .addr_lo   (req_addr[1:0]),
        .size      (req_size),
        .misaligned(misaligned)
    );

    l1chk_port_route u_route (
        .dag      (req_dag),
        .cacheable(req_cacheable),
        .bank     (req_bank),
        .pref     (port_pref),
        .sel      (route_sel)
    );

    // Cause selection: misalignment outranks region violations
    always_comb begin
        cause_d = CAUSE_NONE;
        if (req_valid && !prot_en) begin
            if (misaligned)
                cause_d = CAUSE_ALIGN;
            else if (region.reg_hit && (req_dag || req_user))
                cause_d = CAUSE_REG;
            else if (region.rsvd_hit)
                cause_d = CAUSE_RSVD;
        end
    end

    // Port-hold controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = req_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            cause_q   <= CAUSE_NONE;
            rsp_exc   <= 1'b0;
            port_sel  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            cause_q   <= cause_d;
            rsp_exc   <= (cause_d != CAUSE_NONE);
            if (state_q == ST_IDLE && req_valid)
                port_sel <= route_sel;
        end
    end

    assign rsp_cause = cause_q;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R11
    exc_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc |-> rsp_valid);

    // R6
    prot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_en) |=> !rsp_exc);

    // R7
    align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_en && misaligned) |=> rsp_cause == 2'b10);

    // R10
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid) |=> $stable(port_sel));

    // R8
    cache_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid && req_cacheable) |=> port_sel == $past(req_bank));
endmodule

// File: tb/l1_access_checker_bench.sv
module l1_access_checker_bench;
    localparam logic [31:0] RSV_LO   = 32'hFF90_0000;
    localparam logic [31:0] RSV_HI   = 32'hFF9F_FFFF;
    localparam logic [31:0] REG_BASE = 32'hFFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_dag = 1'b0;
    logic        req_user = 1'b0;
    logic        req_cacheable = 1'b0;
    logic        req_bank = 1'b0;
    logic        prot_en = 1'b0;
    logic [1:0]  port_pref = '0;
    logic        rsp_valid, rsp_exc, port_sel;
    logic [1:0]  rsp_cause;

    int tests = 0;
    int fails = 0;
    logic prev_valid = 1'b0;
    logic exp_port   = 1'b0;

    always #5 clk = ~clk;

    l1_access_checker u_l1_access_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_dag(req_dag), .req_user(req_user),
        .req_cacheable(req_cacheable), .req_bank(req_bank), .prot_en(prot_en),
        .port_pref(port_pref), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
        .rsp_cause(rsp_cause), .port_sel(port_sel)
    );

    function automatic logic [1:0] model_cause(logic v, logic [31:0] a, logic [1:0] s,
                                               logic d, logic u, logic pe);
        logic mis;
        mis = (s == 2'b01) ? a[0] : (s[1] ? (a[1:0] != 2'b00) : 1'b0);
        if (!v || pe) return 2'b00;
        if (mis) return 2'b10;
        if (a >= REG_BASE && (d || u)) return 2'b11;
        if (a >= RSV_LO && a <= RSV_HI) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic model_route(logic d, logic c, logic b, logic [1:0] p);
        return c ? b : p[d];
    endfunction

    function automatic string cause_tag(logic [1:0] c, logic [31:0] a, logic d, logic pe);
        if (pe) return "R6";
        case (c)
            2'b10: return (a >= REG_BASE || (a >= RSV_LO && a <= RSV_HI)) ? "R7" : "R2";
            2'b11: return d ? "R4" : "R5";
            2'b01: return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic check(logic ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, then check at the following negedge
    task automatic cycle(logic v, logic [31:0] a, logic [1:0] s, logic d, logic u,
                         logic c, logic b, logic pe, logic [1:0] p);
        logic [1:0] ec;
        string      tg;
        req_valid = v; req_addr = a; req_size = s; req_dag = d; req_user = u;
        req_cacheable = c; req_bank = b; prot_en = pe; port_pref = p;
        ec = model_cause(v, a, s, d, u, pe);
        tg = cause_tag(ec, a, d, pe);
        if (v && !prev_valid) exp_port = model_route(d, c, b, p);
        @(negedge clk);
        check(rsp_valid == v, "R1", "rsp_valid", int'(rsp_valid), int'(v));
        check(rsp_cause == ec, tg, "rsp_cause", int'(rsp_cause), int'(ec));
        check(rsp_exc == (ec != 2'b00), tg, "rsp_exc", int'(rsp_exc), int'(ec != 2'b00));
        check(port_sel == exp_port, (v && prev_valid) ? "R10" : (c ? "R8" : "R9"),
              "port_sel", int'(port_sel), int'(exp_port));
        prev_valid = v;
    endtask

    function automatic logic [31:0] pick_addr(int unsigned r);
        case (r % 5)
            0: return RSV_LO + ($urandom % 32'h100);
            1: return RSV_HI - ($urandom % 32'h100);
            2: return REG_BASE + ($urandom % 32'h1000);
            3: return REG_BASE - 32'd1 - ($urandom % 32'h40);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        int unsigned wd;
        wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 50000) begin
                tests++; fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0 && rsp_exc == 1'b0, "R1", "reset valid/exc",
              int'({rsp_valid, rsp_exc}), 0);
        check(rsp_cause == 2'b00 && port_sel == 1'b0, "R1", "reset cause/port",
              int'({rsp_cause, port_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        cycle(1, REG_BASE + 32'd1, 2'b10, 1, 0, 0, 0, 0, 2'b10);  // R7 misaligned + reg
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);                // R11 idle
        cycle(1, REG_BASE + 32'd4, 2'b10, 0, 0, 0, 0, 0, 2'b01);  // R5 DAG0 supervisor ok, R9
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);
        cycle(1, REG_BASE, 2'b00, 1, 0, 0, 0, 0, 2'b00);          // R4 DAG1 supervisor
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);
        cycle(1, REG_BASE + 32'd8, 2'b01, 0, 1, 1, 1, 0, 2'b00);  // R5 user, R8 bank 1
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);
        cycle(1, RSV_LO, 2'b10, 0, 0, 1, 0, 0, 2'b11);            // R3 window low edge, R8
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);
        cycle(1, RSV_HI, 2'b00, 1, 0, 0, 0, 0, 2'b10);            // R3 high edge, R9 pref1
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);
        cycle(1, REG_BASE + 32'd3, 2'b01, 1, 1, 0, 0, 1, 2'b00);  // R6 prot enabled
        // R10 held request with changing routing inputs
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);
        cycle(1, 32'h0000_1000, 2'b10, 0, 0, 0, 0, 0, 2'b01);
        cycle(1, 32'h0000_1000, 2'b10, 1, 0, 0, 0, 0, 2'b00);
        cycle(1, 32'h0000_1000, 2'b10, 0, 0, 1, 0, 0, 2'b00);
        cycle(0, '0, 2'b00, 0, 0, 0, 0, 0, 2'b00);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = pick_addr($urandom);
            cycle(($urandom % 4) != 0, a, 2'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), ($urandom % 5) == 0, 2'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule